// File: doc/BRIEF.md
# Fixed-Point Logical Execution Unit

This unit executes the bitwise-logical and sign-extension group of a RISC integer pipeline. Each cycle it may accept one operation: two 64-bit register operands, a 16-bit unsigned immediate, a 5-bit operation code, a record flag and a valid strobe. One cycle later it presents the 64-bit result together with a 4-bit condition field and a write-enable for that field. Decode, register file access and the origin of the summary-overflow bit are outside the unit. The summary-overflow bit arrives on its own input and is copied into the condition field.

The register-form operations combine the two register operands. The immediate forms combine the first operand with the zero-extended immediate, either in place or moved up by 16 bits. The sign-extension forms widen the low byte, halfword or word of the first operand. Each operation follows its own rule for the condition field. The AND-immediate forms always write it. The OR and XOR immediate forms never write it. The register forms and the sign extensions write it only when the record flag is set.

Operation codes are as follows. Register form: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 equivalence (XNOR), 6 AND-with-complement, 7 OR-with-complement. Immediate form: 8 AND-imm, 9 OR-imm, 10 XOR-imm, 11 AND-imm-shifted, 12 OR-imm-shifted, 13 XOR-imm-shifted. Sign extension: 14 byte, 15 halfword, 16 word. Codes 17 to 31 are undefined.

Top module: `logic_eu_top`

## Requirements
- R1: Codes 0 to 5 produce a&b, a|b, a^b, ~(a&b), ~(a|b) and ~(a^b) respectively.
- R2: Code 6 produces a & ~b and code 7 produces a | ~b; only the second operand is inverted.
- R3: Codes 8, 9 and 10 combine a with the immediate zero-extended to 64 bits (AND, OR, XOR), ignoring b.
- R4: Codes 11, 12 and 13 combine a with a value holding the immediate in bits 31:16 and zeros in all other bits (AND, OR, XOR).
- R5: Codes 14, 15 and 16 copy bit 7, 15 or 31 of a into all higher bits and keep the bits below it.
- R6: Codes 8 and 11 assert cond_we whatever the record flag.
- R7: Codes 9, 10, 12 and 13 never assert cond_we, even with the record flag set.
- R8: Codes 0 to 7 and 14 to 16 assert cond_we exactly when the record flag is 1.
- R9: When written, cond bit 3 is set if the result is negative as a signed 64-bit value, bit 2 if it is positive, bit 1 if it is zero, and bit 0 equals so_in of the issuing cycle.
- R10: out_valid is high in the cycle after a cycle with in_valid high and low otherwise; cond_we is never high without out_valid.
- R11: Codes 17 to 31 give a zero result and never assert cond_we.
- R12: After reset, out_valid, cond_we, result and cond are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation issued this cycle |
| op_sel | input | 5 | Operation code |
| rec | input | 1 | Record flag for register and sign-extension forms |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm | input | 16 | Unsigned immediate |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Operation result |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |
| cond_we | output | 1 | Condition field write-enable |

## Verification
The bench builds the unit with its default widths: a 64-bit datapath and a 16-bit immediate. With these values the shifted immediate lands in bits 31:16. The three sign-extension points at bits 7, 15 and 31 can each be hit with operands whose high bits hold the opposite value. Operands with bit 63 set, operands with bit 63 clear and zero results make each of the three comparison flags reachable. Both record-flag values are applied to every condition-write rule.

// File: rtl/logic_eu_pkg.sv
package logic_eu_pkg;

    localparam int OP_W    = 5;
    localparam int COND_W  = 4;
    localparam int OP_LAST = 16;

    typedef enum logic [OP_W-1:0] {
        OP_AND   = 5'd0,
        OP_OR    = 5'd1,
        OP_XOR   = 5'd2,
        OP_NAND  = 5'd3,
        OP_NOR   = 5'd4,
        OP_EQV   = 5'd5,
        OP_ANDC  = 5'd6,
        OP_ORC   = 5'd7,
        OP_ANDI  = 5'd8,
        OP_ORI   = 5'd9,
        OP_XORI  = 5'd10,
        OP_ANDIS = 5'd11,
        OP_ORIS  = 5'd12,
        OP_XORIS = 5'd13,
        OP_EXTB  = 5'd14,
        OP_EXTH  = 5'd15,
        OP_EXTW  = 5'd16
    } op_e;

    typedef enum logic [1:0] {FN_AND, FN_OR, FN_XOR, FN_SEXT} fn_e;
    typedef enum logic [1:0] {IMM_NONE, IMM_LO, IMM_HI} imm_e;
    typedef enum logic [1:0] {EXT_B = 2'd0, EXT_H = 2'd1, EXT_W = 2'd2} ext_e;
    typedef enum logic [1:0] {CR_REC, CR_ALWAYS, CR_NEVER} crule_e;

    typedef struct packed {
        logic   legal;
        fn_e    fn;
        logic   inv_b;
        logic   inv_out;
        imm_e   imm;
        ext_e   ext;
        crule_e crule;
    } dec_t;

    function automatic dec_t decode_op(input logic [OP_W-1:0] code);
        dec_t d;
        d.legal   = 1'b1;
        d.fn      = FN_AND;
        d.inv_b   = 1'b0;
        d.inv_out = 1'b0;
        d.imm     = IMM_NONE;
        d.ext     = EXT_B;
        d.crule   = CR_REC;
        case (code)
            OP_AND:   d.fn = FN_AND;
            OP_OR:    d.fn = FN_OR;
            OP_XOR:   d.fn = FN_XOR;
            OP_NAND:  begin d.fn = FN_AND; d.inv_out = 1'b1; end
            OP_NOR:   begin d.fn = FN_OR;  d.inv_out = 1'b1; end
            OP_EQV:   begin d.fn = FN_XOR; d.inv_out = 1'b1; end
            OP_ANDC:  begin d.fn = FN_AND; d.inv_b = 1'b1; end
            OP_ORC:   begin d.fn = FN_OR;  d.inv_b = 1'b1; end
            OP_ANDI:  begin d.fn = FN_AND; d.imm = IMM_LO; d.crule = CR_ALWAYS; end
            OP_ORI:   begin d.fn = FN_OR;  d.imm = IMM_LO; d.crule = CR_NEVER; end
            OP_XORI:  begin d.fn = FN_XOR; d.imm = IMM_LO; d.crule = CR_NEVER; end
            OP_ANDIS: begin d.fn = FN_AND; d.imm = IMM_HI; d.crule = CR_ALWAYS; end
            OP_ORIS:  begin d.fn = FN_OR;  d.imm = IMM_HI; d.crule = CR_NEVER; end
            OP_XORIS: begin d.fn = FN_XOR; d.imm = IMM_HI; d.crule = CR_NEVER; end
            OP_EXTB:  begin d.fn = FN_SEXT; d.ext = EXT_B; end
            OP_EXTH:  begin d.fn = FN_SEXT; d.ext = EXT_H; end
            OP_EXTW:  begin d.fn = FN_SEXT; d.ext = EXT_W; end
            default:  begin d.legal = 1'b0; d.crule = CR_NEVER; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/logic_eu_operand.sv
module logic_eu_operand
    import logic_eu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input  imm_e              mode,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] b_eff
);
    localparam int LO_PAD = DATA_W - IMM_W;
    localparam int HI_PAD = DATA_W - 2 * IMM_W;

    logic [DATA_W-1:0] imm_lo;
    logic [DATA_W-1:0] imm_hi;

    assign imm_lo = {{LO_PAD{1'b0}}, imm};
    assign imm_hi = {{HI_PAD{1'b0}}, imm, {IMM_W{1'b0}}};

    always_comb begin
        case (mode)
            IMM_LO:  b_eff = imm_lo;
            IMM_HI:  b_eff = imm_hi;
            default: b_eff = reg_b;
        endcase
    end
endmodule

// File: rtl/logic_eu_datapath.sv
module logic_eu_datapath
    import logic_eu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  dec_t              dec,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b_eff,
    output logic [DATA_W-1:0] res
);
    localparam int N_EXT = 3;

    logic [DATA_W-1:0] ext_val [N_EXT];
    logic [DATA_W-1:0] b_use;
    logic [DATA_W-1:0] core;

    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        localparam int W = DATA_W >> (N_EXT - k);
        assign ext_val[k] = {{(DATA_W - W){a[W-1]}}, a[W-1:0]};
    end

    assign b_use = dec.inv_b ? ~b_eff : b_eff;

    always_comb begin
        case (dec.fn)
            FN_AND:  core = a & b_use;
            FN_OR:   core = a | b_use;
            FN_XOR:  core = a ^ b_use;
            default: core = ext_val[dec.ext];
        endcase
        if (!dec.legal) begin
            res = '0;
        end else if (dec.inv_out) begin
            res = ~core;
        end else begin
            res = core;
        end
    end
endmodule

// File: rtl/logic_eu_cond.sv
module logic_eu_cond
    import logic_eu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  dec_t              dec,
    input  logic              fire,
    input  logic              rec,
    input  logic              so_in,
    input  logic [DATA_W-1:0] res,
    output logic [COND_W-1:0] cond,
    output logic              we
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (res == '0);
    assign is_neg  = res[DATA_W-1];
    assign cond    = {is_neg, !is_neg && !is_zero, is_zero, so_in};

    always_comb begin
        case (dec.crule)
            CR_ALWAYS: we = fire;
            CR_REC:    we = fire && rec;
            default:   we = 1'b0;
        endcase
    end
endmodule

// File: rtl/logic_eu_top.sv
module logic_eu_top
    import logic_eu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [4:0]        op_sel,
    input  logic              rec,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              so_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        cond,
    output logic              cond_we
);
    dec_t              dec;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] res_c;
    logic [COND_W-1:0] cond_c;
    logic              we_c;

    assign dec = decode_op(op_sel);

    logic_eu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
        .mode  (dec.imm),
        .reg_b (src_b),
        .imm   (imm),
        .b_eff (b_eff)
    );

    logic_eu_datapath #(.DATA_W(DATA_W)) u_datapath (
        .dec   (dec),
        .a     (src_a),
        .b_eff (b_eff),
        .res   (res_c)
    );

    logic_eu_cond #(.DATA_W(DATA_W)) u_cond (
        .dec   (dec),
        .fire  (in_valid),
        .rec   (rec),
        .so_in (so_in),
        .res   (res_c),
        .cond  (cond_c),
        .we    (we_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cond_we   <= 1'b0;
            result    <= '0;
            cond      <= '0;
        end else begin
            out_valid <= in_valid;
            cond_we   <= we_c;
            if (in_valid) begin
                result <= res_c;
                cond   <= cond_c;
            end
        end
    end
endmodule

// File: rtl/logic_eu_chk.sv
module logic_eu_chk
    import logic_eu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [4:0]        op_sel,
    input logic              rec,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W-1:0]  imm,
    input logic              so_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        cond,
    input logic              cond_we
);
    logic andi_op;
    logic noflag_op;
    logic undef_op;

    assign andi_op   = (op_sel == OP_ANDI) || (op_sel == OP_ANDIS);
    assign noflag_op = (op_sel == OP_ORI) || (op_sel == OP_XORI) ||
                       (op_sel == OP_ORIS) || (op_sel == OP_XORIS);
    assign undef_op  = (op_sel > 5'(OP_LAST));

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_we_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> out_valid);
    assert_one_flag_R9: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> ($countones(cond[3:1]) == 1));
    assert_eq_flag_R9: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (cond[1] == (result == '0)));
    assert_lt_flag_R9: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (cond[3] == result[DATA_W-1]));
    assert_andi_writes_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && andi_op) |=> cond_we);
    assert_imm_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && noflag_op) |=> !cond_we);
    assert_undef_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && undef_op) |=> (result == '0 && !cond_we));
endmodule

bind logic_eu_top logic_eu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (.*);

// File: tb/logic_eu_top_tb_top.sv
module logic_eu_top_tb_top;
    localparam int DW = 64;
    localparam int IW = 16;

    typedef struct packed {
        logic [4:0]    op;
        logic          rec;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [IW-1:0] imm;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  1'b1, 64'hF0F0_1234_8000_00FF, 64'h0FF0_FF00_8001_0F0F, 16'h1111},
        '{5'd1,  1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 16'hFFFF},
        '{5'd2,  1'b0, 64'hAAAA_5555_AAAA_5555, 64'hFFFF_0000_FFFF_0000, 16'h0000},
        '{5'd3,  1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0000},
        '{5'd4,  1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 16'h0000},
        '{5'd5,  1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 16'h0000},
        '{5'd6,  1'b1, 64'h7FFF_FFFF_0000_FFFF, 64'h0000_FFFF_0000_00FF, 16'h0000},
        '{5'd7,  1'b0, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0000},
        '{5'd8,  1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 16'h8421},
        '{5'd8,  1'b1, 64'hFFFF_FFFF_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF},
        '{5'd9,  1'b1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 16'hBEEF},
        '{5'd10, 1'b0, 64'h0000_0000_0000_FFFF, 64'h1234_0000_0000_0000, 16'h00FF},
        '{5'd11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 16'hC3A5},
        '{5'd12, 1'b1, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 16'h8001},
        '{5'd13, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0000, 16'h0F0F},
        '{5'd14, 1'b1, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0000, 16'h0000},
        '{5'd14, 1'b0, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0000_0000_0000_0000, 16'h0000},
        '{5'd15, 1'b1, 64'h1234_5678_0000_8001, 64'h0000_0000_0000_0000, 16'h0000},
        '{5'd15, 1'b1, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0000_0000_0000_0000, 16'h0000},
        '{5'd16, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000, 16'h0000},
        '{5'd16, 1'b1, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0000, 16'h0000},
        '{5'd2,  1'b1, 64'h0123_4567_89AB_CDEF, 64'hF0F0_F0F0_F0F0_F0F0, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [4:0]    op_sel = '0;
    logic          rec = 1'b0;
    logic [DW-1:0] src_a = '0;
    logic [DW-1:0] src_b = '0;
    logic [IW-1:0] imm = '0;
    logic          so_in = 1'b0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic [3:0]    cond;
    logic          cond_we;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    logic_eu_top #(.DATA_W(DW), .IMM_W(IW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .rec(rec),
        .src_a(src_a), .src_b(src_b), .imm(imm), .so_in(so_in),
        .out_valid(out_valid), .result(result), .cond(cond), .cond_we(cond_we)
    );

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_res(input vec_t v);
        logic [DW-1:0] zi;
        logic [DW-1:0] si;
        zi = DW'(v.imm);
        si = DW'(v.imm) << 16;
        case (v.op)
            5'd0:  return v.a & v.b;
            5'd1:  return v.a | v.b;
            5'd2:  return v.a ^ v.b;
            5'd3:  return ~(v.a & v.b);
            5'd4:  return ~(v.a | v.b);
            5'd5:  return ~(v.a ^ v.b);
            5'd6:  return v.a & ~v.b;
            5'd7:  return v.a | ~v.b;
            5'd8:  return v.a & zi;
            5'd9:  return v.a | zi;
            5'd10: return v.a ^ zi;
            5'd11: return v.a & si;
            5'd12: return v.a | si;
            5'd13: return v.a ^ si;
            5'd14: return {{56{v.a[7]}}, v.a[7:0]};
            5'd15: return {{48{v.a[15]}}, v.a[15:0]};
            5'd16: return {{32{v.a[31]}}, v.a[31:0]};
            default: return '0;
        endcase
    endfunction

    function automatic logic model_we(input vec_t v);
        if (v.op == 5'd8 || v.op == 5'd11) return 1'b1;
        if (v.op >= 5'd9 && v.op <= 5'd13) return 1'b0;
        if (v.op > 5'd16) return 1'b0;
        return v.rec;
    endfunction

    function automatic string res_tag(input logic [4:0] op);
        if (op <= 5'd5) return "R1";
        if (op <= 5'd7) return "R2";
        if (op <= 5'd10) return "R3";
        if (op <= 5'd13) return "R4";
        if (op <= 5'd16) return "R5";
        return "R11";
    endfunction

    function automatic string we_tag(input logic [4:0] op);
        if (op == 5'd8 || op == 5'd11) return "R6";
        if (op >= 5'd9 && op <= 5'd13) return "R7";
        if (op > 5'd16) return "R11";
        return "R8";
    endfunction

    task automatic issue(input vec_t v, input logic so);
        logic [DW-1:0] er;
        logic [3:0]    ec;
        @(negedge clk);
        op_sel = v.op; rec = v.rec; src_a = v.a; src_b = v.b; imm = v.imm;
        so_in = so; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        er = model_res(v);
        ec[3] = $signed(er) < 0;
        ec[2] = $signed(er) > 0;
        ec[1] = (er == 0);
        ec[0] = so;
        check("R10", "out_valid", DW'(out_valid), DW'(1));
        check(res_tag(v.op), "result", result, er);
        check(we_tag(v.op), "cond_we", DW'(cond_we), DW'(model_we(v)));
        if (model_we(v)) check("R9", "cond", DW'(cond), DW'(ec));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12", "out_valid", DW'(out_valid), DW'(0));
        check("R12", "cond_we", DW'(cond_we), DW'(0));
        check("R12", "result", result, '0);
        check("R12", "cond", DW'(cond), DW'(0));
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i], i[0]);
        end

        // R9: summary-overflow copied, zero result sets EQ
        issue('{5'd0, 1'b1, 64'hFF00, 64'h00FF, 16'h0}, 1'b1);
        // R6: AND-immediate writes with rec clear and negative operand masked to zero
        issue('{5'd11, 1'b0, 64'h8000_0000_0000_FFFF, '0, 16'hFFFF}, 1'b0);
        // R7: XOR-immediate shifted with rec set still does not write
        issue('{5'd13, 1'b1, 64'h8000_0000_0000_0000, '0, 16'h1}, 1'b1);
        // R8: register form with rec clear does not write
        issue('{5'd4, 1'b0, '0, '0, 16'h0}, 1'b0);
        // R11: undefined codes after a nonzero result
        issue('{5'd1, 1'b1, 64'h1, 64'h2, 16'h0}, 1'b0);
        issue('{5'd17, 1'b1, 64'hDEAD_BEEF, 64'h1, 16'hFFFF}, 1'b0);
        issue('{5'd31, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF}, 1'b1);

        // R10: idle cycle yields no valid and no write
        @(negedge clk);
        check("R10", "idle out_valid", DW'(out_valid), DW'(0));
        check("R10", "idle cond_we", DW'(cond_we), DW'(0));

        // R10: back-to-back issue, each result one cycle later
        @(negedge clk);
        op_sel = 5'd1; rec = 1'b1; src_a = 64'h10; src_b = 64'h01; in_valid = 1'b1;
        @(negedge clk);
        check("R10", "b2b first result", result, 64'h11);
        check("R10", "b2b first valid", DW'(out_valid), DW'(1));
        op_sel = 5'd0; src_a = 64'hF0; src_b = 64'h3C;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", "b2b second result", result, 64'h30);
        check("R10", "b2b second valid", DW'(out_valid), DW'(1));
        @(negedge clk);
        check("R10", "b2b drained", DW'(out_valid), DW'(0));

        // R12: reset mid-run clears outputs
        op_sel = 5'd1; src_a = 64'h5; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R12", "reset result", result, '0);
        check("R12", "reset out_valid", DW'(out_valid), DW'(0));
        rst = 1'b0;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule